// File: doc/BRIEF.md
# Double-Buffered Capture/Compare Channel

This block is a single timer channel that either timestamps edges on an event pin or acts when a timer reaches a programmed value. It watches two free-running timer values supplied from outside and a control register written by the CPU. That register picks the timer, the mode, and either the qualifying pin edge or the set of actions to take on a match.

In capture mode a qualified edge first stores the selected timer value in a one-entry holding buffer. The buffer then moves into the CPU-visible event-time register, and that move raises an interrupt-pending flag. If a later edge arrives while the register is still unread, its timestamp waits in the buffer. The CPU read strobe then moves it forward automatically and raises the flag again. A full buffer either accepts the newest timestamp or drops it and records an overrun, depending on an overwrite control.

In compare mode the event-time register holds a target. On a tick of the selected timer whose value equals the target, the channel can toggle its output pin, pulse a timer-reset request and pulse a conversion-start request. It sets the pending flag on the same clock edge as these actions.

Top module: `capcmp_channel`

## Requirements
- R1: After reset, timeReg is 0 and pending, irq, overrun, pinOut, timerRst and adcStart are all 0.
- R2: A cfgWr pulse loads cfgData into the control register, with this bit layout: bit 0 selects the timer (0 = timerA/tickA, 1 = timerB/tickB); bit 1 selects the mode (0 = capture, 1 = compare); bits 3:2 select the capture edge; bit 4 enables overwrite; bit 5 enables pin toggle; bit 6 enables the timer-reset pulse; bit 7 enables the conversion-start pulse.
- R3: pinIn passes through two synchronizing flip-flops before edge detection. The capture-edge codes are 00 = none, 01 = rising, 10 = falling and 11 = both. When the buffer and the register are both empty, the pin level first sampled at clock edge k reaches timeReg at edge k+3. The value stored is the selected timer value present just before edge k+2.
- R4: A buffered value moves into timeReg when the register holds no unread value, and pending is set on that same edge.
- R5: A qualified edge that arrives while timeReg is unread and the buffer is empty goes into the buffer, and timeReg keeps its value.
- R6: A timeRd pulse in capture mode moves any buffered value into timeReg on that edge and sets pending again. With the buffer empty, the read marks timeReg as read.
- R7: A qualified edge that arrives while the buffer is full and not moving replaces the buffered value when overwrite is 1. When overwrite is 0, the edge is dropped and overrun is set. Overrun is sticky until the next cfgWr.
- R8: In compare mode, a cycle with the selected tick high and the selected timer equal to timeReg fires the enabled actions on the next edge. The actions are a pinOut toggle, a one-cycle timerRst pulse and a one-cycle adcStart pulse (the last only when HAS_ADC is 1). pending is set on that same edge.
- R9: timeWr loads timeWrData into timeReg only in compare mode and has no effect in capture mode.
- R10: pendClr clears pending, and a hardware set on the same edge wins over the clear.
- R11: irq is high exactly when pending and irqEn are both high.
- R12: A cfgWr edge empties the buffer, marks timeReg as read, clears overrun, and suppresses any capture or compare action in that cycle.
- R13: With bit 0 of the control register set to 1, captures and matches use timerB and tickB instead of timerA and tickA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| timerA | input | W | First timer value |
| timerB | input | W | Second timer value |
| tickA | input | 1 | timerA holds a new value this cycle |
| tickB | input | 1 | timerB holds a new value this cycle |
| pinIn | input | 1 | Asynchronous event pin |
| cfgWr | input | 1 | Control register write strobe |
| cfgData | input | 8 | Control register write data |
| timeWr | input | 1 | Event-time register write strobe |
| timeWrData | input | W | Event-time register write data |
| timeRd | input | 1 | CPU read strobe of the event-time register |
| pendClr | input | 1 | Write-one-to-clear of the pending flag |
| irqEn | input | 1 | Interrupt enable |
| timeReg | output | W | Event-time register |
| pending | output | 1 | Interrupt-pending flag |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky dropped-capture flag |
| pinOut | output | 1 | Compare toggle output |
| timerRst | output | 1 | One-cycle timer reset request |
| adcStart | output | 1 | One-cycle conversion start request |

## Verification
Four invariants are checked by assertions on every cycle:
- The holding buffer only changes when it is loaded.
- timeReg changes only through a buffer move or a CPU write.
- pending is always set after a move or a match, even when a clear arrives on the same edge.
- overrun stays set until a configuration write, and pinOut changes only after a toggle strobe.

The bench scenarios are needed for the end-to-end behaviour. They show the three-edge capture latency and the edge-select codes, the second capture held until a read, the overwrite-versus-drop choice on a third edge, the timer selection, and the compare actions landing on the cycle after a matching tick.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  // Control register layout, MSB first (bit 7 .. bit 0)
  typedef struct packed {
    logic       actAdc;
    logic       actReset;
    logic       actToggle;
    logic       overwrite;
    logic [1:0] edgeSel;
    logic       cmpMode;
    logic       timerSel;
  } chanCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBuf;
    logic moveBuf;
    logic loadCpu;
    logic fireToggle;
    logic fireReset;
    logic fireAdc;
  } chanStb_t;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pinIn,
  input  logic     cfgWr,
  input  logic [7:0] cfgData,
  input  logic     timeRd,
  input  logic     timeWr,
  input  logic     pendClr,
  input  logic     cmpEq,
  output logic     timerSel,
  output chanStb_t stb,
  output logic     pending,
  output logic     overrun
);

  localparam int HIST = SYNC_STAGES + 1;

  chanCfg_t        cfg;
  logic [HIST-1:0] pinHist;
  logic            bufValid;
  logic            timeFull;
  logic            rise, fall, evt;
  logic            capMode, hit, dropEvt;

  // synchronizer plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinHist <= '0;
    else       pinHist <= {pinHist[HIST-2:0], pinIn};
  end

  assign rise = pinHist[HIST-2] & ~pinHist[HIST-1];
  assign fall = ~pinHist[HIST-2] & pinHist[HIST-1];

  always_comb begin
    unique case (cfg.edgeSel)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  assign capMode  = ~cfg.cmpMode;
  assign timerSel = cfg.timerSel;

  always_comb begin
    stb         = '0;
    stb.moveBuf = capMode && !cfgWr && bufValid && (!timeFull || timeRd);
    stb.loadBuf = capMode && !cfgWr && evt && (!bufValid || stb.moveBuf || cfg.overwrite);
    stb.loadCpu = !capMode && timeWr;
    hit         = !capMode && !cfgWr && cmpEq;
    stb.fireToggle = hit && cfg.actToggle;
    stb.fireReset  = hit && cfg.actReset;
    stb.fireAdc    = hit && cfg.actAdc;
  end

  assign dropEvt = capMode && !cfgWr && evt && bufValid && !stb.moveBuf && !cfg.overwrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      bufValid <= 1'b0;
      timeFull <= 1'b0;
      overrun  <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (cfgWr) cfg <= chanCfg_t'(cfgData);

      if (cfgWr)            bufValid <= 1'b0;
      else if (stb.loadBuf) bufValid <= 1'b1;
      else if (stb.moveBuf) bufValid <= 1'b0;

      if (cfgWr)                  timeFull <= 1'b0;
      else if (stb.moveBuf)       timeFull <= 1'b1;
      else if (capMode && timeRd) timeFull <= 1'b0;

      if (cfgWr)        overrun <= 1'b0;
      else if (dropEvt) overrun <= 1'b1;

      if (stb.moveBuf || hit) pending <= 1'b1;
      else if (pendClr)       pending <= 1'b0;
    end
  end

  AST_PEND_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.moveBuf || hit) |=> pending); // R10

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !cfgWr) |=> overrun); // R7

endmodule

// File: rtl/capcmp_dp.sv
module capcmp_dp
  import capcmp_pkg::*;
#(
  parameter int W       = 16,
  parameter bit HAS_ADC = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] timerA,
  input  logic [W-1:0] timerB,
  input  logic         tickA,
  input  logic         tickB,
  input  logic         timerSel,
  input  chanStb_t     stb,
  input  logic [W-1:0] timeWrData,
  output logic         cmpEq,
  output logic [W-1:0] timeReg,
  output logic         pinOut,
  output logic         timerRst,
  output logic         adcStart
);

  logic [W-1:0] selTimer;
  logic         selTick;
  logic [W-1:0] bufReg;

  assign selTimer = timerSel ? timerB : timerA;
  assign selTick  = timerSel ? tickB  : tickA;
  assign cmpEq    = selTick && (selTimer == timeReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg   <= '0;
      timeReg  <= '0;
      pinOut   <= 1'b0;
      timerRst <= 1'b0;
    end else begin
      if (stb.loadBuf) bufReg <= selTimer;
      if (stb.moveBuf)      timeReg <= bufReg;
      else if (stb.loadCpu) timeReg <= timeWrData;
      if (stb.fireToggle) pinOut <= ~pinOut;
      timerRst <= stb.fireReset;
    end
  end

  generate
    if (HAS_ADC) begin : g_adc
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) adcStart <= 1'b0;
        else       adcStart <= stb.fireAdc;
      end
    end else begin : g_noAdc
      assign adcStart = 1'b0;
    end
  endgenerate

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadBuf |=> $stable(bufReg)); // R5

  AST_TIME_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.moveBuf && !stb.loadCpu) |=> $stable(timeReg)); // R9

  AST_TOGGLE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut != $past(pinOut)) |-> $past(stb.fireToggle)); // R8

endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
  import capcmp_pkg::*;
#(
  parameter int W       = 16,
  parameter bit HAS_ADC = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] timerA,
  input  logic [W-1:0] timerB,
  input  logic         tickA,
  input  logic         tickB,
  input  logic         pinIn,
  input  logic         cfgWr,
  input  logic [7:0]   cfgData,
  input  logic         timeWr,
  input  logic [W-1:0] timeWrData,
  input  logic         timeRd,
  input  logic         pendClr,
  input  logic         irqEn,
  output logic [W-1:0] timeReg,
  output logic         pending,
  output logic         irq,
  output logic         overrun,
  output logic         pinOut,
  output logic         timerRst,
  output logic         adcStart
);

  chanStb_t stb;
  logic     cmpEq;
  logic     timerSel;

  capcmp_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cfgWr(cfgWr), .cfgData(cfgData),
    .timeRd(timeRd), .timeWr(timeWr), .pendClr(pendClr), .cmpEq(cmpEq),
    .timerSel(timerSel), .stb(stb), .pending(pending), .overrun(overrun)
  );

  capcmp_dp #(.W(W), .HAS_ADC(HAS_ADC)) u_dp (
    .clk(clk), .rstN(rstN), .timerA(timerA), .timerB(timerB),
    .tickA(tickA), .tickB(tickB), .timerSel(timerSel), .stb(stb),
    .timeWrData(timeWrData), .cmpEq(cmpEq), .timeReg(timeReg),
    .pinOut(pinOut), .timerRst(timerRst), .adcStart(adcStart)
  );

  assign irq = pending & irqEn;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (irq == (pending && irqEn))); // R11

endmodule

// File: tb/capcmp_channel_tb.sv
module capcmp_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rstN = 1'b0;
  logic [W-1:0] timerA = '0, timerB = '0;
  logic         tickA = 1'b1, tickB = 1'b0;
  logic         pinIn = 0, cfgWr = 0, timeWr = 0, timeRd = 0, pendClr = 0, irqEn = 0;
  logic [7:0]   cfgData = '0;
  logic [W-1:0] timeWrData = '0;
  logic [W-1:0] timeReg;
  logic         pending, irq, overrun, pinOut, timerRst, adcStart;

  capcmp_channel #(.W(W), .HAS_ADC(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .timerA(timerA), .timerB(timerB),
    .tickA(tickA), .tickB(tickB), .pinIn(pinIn), .cfgWr(cfgWr),
    .cfgData(cfgData), .timeWr(timeWr), .timeWrData(timeWrData),
    .timeRd(timeRd), .pendClr(pendClr), .irqEn(irqEn), .timeReg(timeReg),
    .pending(pending), .irq(irq), .overrun(overrun), .pinOut(pinOut),
    .timerRst(timerRst), .adcStart(adcStart)
  );

  int    compared = 0, mismatched = 0, cycles = 0;
  bit    done = 0;
  string req = "R1";

  // free-running timers: A every cycle, B every second cycle
  always @(posedge clk) begin
    #1;
    timerA = timerA + 1'b1;
    tickB  = ~tickB;
    if (tickB) timerB = timerB + 1'b1;
  end

  // behavioural reference model
  bit           pinQ[$] = '{0, 0, 0};
  logic [7:0]   mCfg = '0;
  logic [W-1:0] mTime = '0, mBuf = '0;
  bit           mBufV = 0, mFull = 0, mOvr = 0, mPend = 0, mPin = 0, mRst = 0, mAdc = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      pinQ = '{0, 0, 0};
      mCfg = '0; mTime = '0; mBuf = '0;
      mBufV = 0; mFull = 0; mOvr = 0; mPend = 0; mPin = 0; mRst = 0; mAdc = 0;
    end else begin
      bit rising, falling, evt, hit, setP, moving, wasBufV;
      logic [W-1:0] tmr;
      bit tk;
      rising  = pinQ[1] && !pinQ[2];
      falling = !pinQ[1] && pinQ[2];
      case (mCfg[3:2])
        2'b01:   evt = rising;
        2'b10:   evt = falling;
        2'b11:   evt = rising || falling;
        default: evt = 0;
      endcase
      tmr = mCfg[0] ? timerB : timerA;
      tk  = mCfg[0] ? tickB : tickA;
      setP = 0; mRst = 0; mAdc = 0;
      if (mCfg[1] && timeWr) mTime = timeWrData;
      else if (!mCfg[1] && timeWr) ; // capture mode ignores CPU writes (R9)
      if (cfgWr) begin
        mCfg = cfgData; mBufV = 0; mFull = 0; mOvr = 0;
      end else if (!mCfg[1]) begin
        wasBufV = mBufV;
        moving  = mBufV && (!mFull || timeRd);
        if (moving) begin
          mTime = mBuf; mFull = 1; setP = 1; mBufV = 0;
        end else if (timeRd) mFull = 0;
        if (evt) begin
          if (!wasBufV || moving) begin mBuf = tmr; mBufV = 1; end
          else if (mCfg[4]) mBuf = tmr;
          else mOvr = 1;
        end
      end else begin
        hit = tk && (tmr == mTime);
        if (hit) begin
          setP = 1;
          if (mCfg[5]) mPin = !mPin;
          mRst = mCfg[6];
          mAdc = mCfg[7];
        end
      end
      if (setP) mPend = 1;
      else if (pendClr) mPend = 0;
      pinQ.push_front(pinIn);
      void'(pinQ.pop_back());
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (timeReg !== mTime) begin mismatched++;
        $display("FAIL %s timeReg act %h exp %h", req, timeReg, mTime); end
      if (pending !== mPend) begin mismatched++;
        $display("FAIL %s pending act %b exp %b", req, pending, mPend); end
      if (irq !== (mPend && irqEn)) begin mismatched++;
        $display("FAIL %s irq act %b exp %b", req, irq, mPend && irqEn); end
      if (overrun !== mOvr) begin mismatched++;
        $display("FAIL %s overrun act %b exp %b", req, overrun, mOvr); end
      if (pinOut !== mPin) begin mismatched++;
        $display("FAIL %s pinOut act %b exp %b", req, pinOut, mPin); end
      if (timerRst !== mRst) begin mismatched++;
        $display("FAIL %s timerRst act %b exp %b", req, timerRst, mRst); end
      if (adcStart !== mAdc) begin mismatched++;
        $display("FAIL %s adcStart act %b exp %b", req, adcStart, mAdc); end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog act %0d exp <= 50000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic writeCfg(input logic [7:0] v);
    cfgData = v; cfgWr = 1; cyc(1); cfgWr = 0;
  endtask

  task automatic readTime();
    timeRd = 1; cyc(1); timeRd = 0;
  endtask

  task automatic pinSet(input bit v, input int n);
    pinIn = v; cyc(n);
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    req = "R1"; cyc(3);
    req = "R2"; writeCfg(8'h04);               // timerA, capture, rising
    req = "R3"; pinSet(1, 6);
    req = "R4"; cyc(1);
    req = "R3"; pinSet(0, 6);                  // falling ignored on rising select
    req = "R6"; readTime(); cyc(3);
    req = "R3"; writeCfg(8'h0C);               // both edges
    pinSet(1, 6);
    req = "R5"; pinSet(0, 6);                  // second capture held
    req = "R11"; irqEn = 1; cyc(2);
    req = "R6"; readTime(); cyc(3);
    readTime(); cyc(3);                        // empty buffer read
    req = "R3"; writeCfg(8'h08);               // falling only
    pinSet(1, 6); pinSet(0, 6); readTime(); cyc(2);
    req = "R7"; writeCfg(8'h0C);               // no overwrite
    pinSet(1, 6); pinSet(0, 6); pinSet(1, 6); cyc(2);
    req = "R12"; writeCfg(8'h1C);              // overwrite on, clears overrun
    req = "R7"; pinSet(0, 6); pinSet(1, 6); pinSet(0, 6);
    readTime(); cyc(2); readTime(); cyc(2);
    req = "R10"; pendClr = 1; cyc(1); pendClr = 0; cyc(2);
    pinSet(1, 6); pinSet(0, 6);
    pendClr = 1; timeRd = 1; cyc(1); pendClr = 0; timeRd = 0; cyc(2);
    req = "R11"; irqEn = 0; cyc(2); irqEn = 1;
    req = "R13"; writeCfg(8'h0D);              // timerB, both edges
    pinSet(1, 6); readTime(); pinSet(0, 6); readTime(); cyc(2);
    req = "R9"; timeWrData = 16'hBEEF; timeWr = 1; cyc(1); timeWr = 0; cyc(2);
    req = "R8"; writeCfg(8'hE3);               // compare on timerB, all actions
    timeWrData = timerB + 16'd6; timeWr = 1; cyc(1); timeWr = 0; cyc(20);
    pendClr = 1; cyc(1); pendClr = 0;
    writeCfg(8'h62);                           // compare on timerA, toggle+reset
    timeWrData = timerA + 16'd5; timeWr = 1; cyc(1); timeWr = 0; cyc(10);
    req = "R12"; writeCfg(8'h00);              // capture, edge none
    req = "R3"; pinSet(1, 6); pinSet(0, 6); cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule